// File: doc/BRIEF.md
# Indexed Clock-Chip Register Port with Interrupt Flags

This block is the byte-wide register front end of a real-time clock. A host sees two addresses. A write to the even address selects one of 128 byte locations. The odd address then reads or writes the selected byte. Four locations are control and status registers. All the others, including the bytes that hold time and alarm values, are plain storage. Counting the time and comparing the alarm happen outside this block. It receives their results as single-cycle event pulses and a live update-in-progress level.

The block latches three event flags into a status register: update ended, alarm and periodic. It drives a level interrupt whenever an enabled flag is newly latched. The periodic events come from an internal divider of a reference tick input, and a four-bit field selects its rate. Reading the status register acknowledges everything at once. A separate warm reset returns the interrupt state to idle. It preserves most stored bytes, and keeps one byte only when that byte holds a marker value.

Top module: `cmos_regport`

## Requirements
- R1: A write with `bus_sel`=0 stores `bus_wdata[6:0]` as the index, and bit 7 is dropped. A read with `bus_sel`=0 returns 0xFF.
- R2: After power-on reset (`rst_n` low), the control register at index 0x0A reads 0x26, the one at 0x0B reads 0x02, the one at 0x0C reads 0x00 and the one at 0x0D reads 0x80. `irq` is low.
- R3: Any index outside 0x0A..0x0D is a storage byte that reads back the last value written to it. Data accesses use `bus_sel`=1.
- R4: Writes to 0x0C and 0x0D have no effect. Bit 7 of 0x0A ignores writes. It reads as `uip_in` while bit 7 of 0x0B is 0, and as 0 while that bit is 1. Bits 6:0 of 0x0A read back as written.
- R5: Status register 0x0C has this layout: bit 7 interrupt request, bit 6 periodic, bit 5 alarm, bit 4 update ended, and bits 3:0 always 0. Bits 6, 5 and 4 of 0x0B enable the matching flags. An event pulse sets its flag at the next clock edge, whether or not it is enabled.
- R6: When an event sets a flag that was clear and whose enable is 1, bit 7 of 0x0C and `irq` go high at the same edge.
- R7: A read of 0x0C returns its current value, and at the next edge it clears every flag and lowers `irq`. An event pulse in the same cycle as that read is still latched.
- R8: A write to 0x0B whose enable bits cover a flag already set in 0x0C raises bit 7 and `irq` at the next edge. Any other write to 0x0B clears bit 7 and lowers `irq`. The event flags are left in place.
- R9: A write to 0x0B with bit 7 set stores bit 4 as 0.
- R10: Bits 3:0 of 0x0A set the periodic rate n, counted in `ref_tick` pulses. The value 0 stops periodic events. The value 1 gives a period of 128 pulses and 2 gives 256. Values 3 to 15 give 2^(n-1). A write that changes n restarts the count, so the first event is latched on the edge of the period-th pulse after the write.
- R11: While `warm_rst_n` is low, bus writes and events are ignored. At the edge, bits 6, 5 and 3 of 0x0B and all of 0x0C are cleared, and `irq` drops. Byte 0x0F keeps 0xFE if it holds 0xFE and otherwise becomes 0x00. Register 0x0A and the other storage bytes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| warm_rst_n | input | 1 | Synchronous active-low warm reset |
| bus_sel | input | 1 | 0 selects the index address, 1 selects the data address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| ref_tick | input | 1 | Reference tick that the periodic divider counts |
| upd_done | input | 1 | Update-ended event pulse from the time counter |
| alarm_hit | input | 1 | Alarm event pulse from the alarm comparator |
| uip_in | input | 1 | Live update-in-progress level from the time counter |
| irq | output | 1 | Level interrupt request |

## Verification
Each event source is pulsed on its own, first with its enable off and then with it on. This separates latching a flag from raising the request. A flag left pending before its enable is written separates the late-enable path from the event path. Then acknowledging the status register in the same cycle as a new event shows that the event survives the clear. The periodic divider is run at its shortest setting, at a special low setting and at zero. Each run shows whether the restart-on-change rule and the period table are honoured on the exact edge. Warm resets with and without the marker byte show that the marker rule applies to that byte alone.

// File: rtl/crp_pkg.sv
// Shared constants for the indexed register port.
// Index values and bit positions are decoded by software and so are fixed.
package crp_pkg;
    localparam int IDX_A      = 10;
    localparam int IDX_B      = 11;
    localparam int IDX_C      = 12;
    localparam int IDX_D      = 13;
    localparam int KEEP_IDX   = 15;
    localparam logic [7:0] KEEP_MAGIC = 8'hFE;
    localparam logic [7:0] A_RST      = 8'h26;
    localparam logic [7:0] B_RST      = 8'h02;
    localparam logic [7:0] D_VAL      = 8'h80;
    localparam logic [7:0] B_WARM_CLR = 8'h68;  // periodic, alarm, square-wave enables
    localparam int B_SET = 7;
    localparam int B_UIE = 4;
    localparam int C_REQ = 7;

    // Periodic interval in reference ticks for rate code n (0 = off).
    function automatic logic [15:0] period_of(input logic [3:0] n);
        case (n)
            4'd0:    period_of = 16'd0;
            4'd1:    period_of = 16'd128;
            4'd2:    period_of = 16'd256;
            default: period_of = 16'd1 << (n - 4'd1);
        endcase
    endfunction
endpackage

// File: rtl/crp_rate_div.sv
// Periodic event divider. Counts reference ticks and emits one pulse
// per selected period. Assumes restart is asserted whenever the rate
// code changes, so the count never exceeds the new period.
module crp_rate_div
    import crp_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] rate,
    input  logic       restart,
    input  logic       tick,
    output logic       pf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [15:0]      per_full;
    logic [CNT_W-1:0] last;
    logic             running;
    logic             at_last;

    // Decode the selected period into a terminal count.
    always_comb begin
        per_full = period_of(rate);
        last     = CNT_W'(per_full - 16'd1);
        running  = (rate != 4'd0);
        at_last  = (cnt_q == last);
        pf_o     = tick && running && at_last && !restart;
    end

    // Advance the tick count, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= '0;
        else if (tick && running)
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end

    // R10: with a live rate the count stays within the period
    assert_cnt_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rate != 4'd0) |-> (cnt_q <= last));
endmodule

// File: rtl/crp_store.sv
// Index register, control registers A and B, and the byte storage.
// Assumes single-cycle write strobes. Warm reset blocks all writes.
module crp_store
    import crp_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              uip_in,
    output logic [ADDR_W-1:0] idx_o,
    output logic [3:0]        rate_o,
    output logic              rate_chg_o,
    output logic              wr_b_o,
    output logic [7:0]        b_wval_o,
    output logic [7:0]        b_o,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] idx_q;
    logic [6:0]        a_q;
    logic [7:0]        b_q;
    logic [7:0]        mem_q [DEPTH];
    logic              wr_data, wr_index, hit_a, hit_b, hit_d, hit_ctrl;

    // Decode the access and the index.
    always_comb begin
        wr_data    = bus_wr && bus_sel && warm_rst_n;
        wr_index   = bus_wr && !bus_sel && warm_rst_n;
        hit_a      = (idx_q == ADDR_W'(IDX_A));
        hit_b      = (idx_q == ADDR_W'(IDX_B));
        hit_d      = (idx_q == ADDR_W'(IDX_D));
        hit_ctrl   = (idx_q >= ADDR_W'(IDX_A)) && (idx_q <= ADDR_W'(IDX_D));
        b_wval_o   = {bus_wdata[7:5], bus_wdata[B_UIE] & ~bus_wdata[B_SET], bus_wdata[3:0]};
        wr_b_o     = wr_data && hit_b;
        rate_chg_o = wr_data && hit_a && (bus_wdata[3:0] != a_q[3:0]);
    end

    // Index register: keeps the low index bits of an even-address write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (wr_index)
            idx_q <= bus_wdata[ADDR_W-1:0];
    end

    // Control registers A and B, with the warm-reset enable clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= A_RST[6:0];
            b_q <= B_RST;
        end else if (!warm_rst_n) begin
            b_q <= b_q & ~B_WARM_CLR;
        end else begin
            if (wr_data && hit_a)
                a_q <= bus_wdata[6:0];
            if (wr_b_o)
                b_q <= b_wval_o;
        end
    end

    // Byte storage with the marker-preserving warm reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
        end else if (!warm_rst_n) begin
            mem_q[KEEP_IDX] <= (mem_q[KEEP_IDX] == KEEP_MAGIC) ? KEEP_MAGIC : 8'h00;
        end else if (wr_data && !hit_ctrl) begin
            mem_q[idx_q] <= bus_wdata;
        end
    end

    // Read mux for every index except the status register.
    always_comb begin
        if (hit_a)
            rdata_o = {uip_in & ~b_q[B_SET], a_q};
        else if (hit_b)
            rdata_o = b_q;
        else if (hit_d)
            rdata_o = D_VAL;
        else
            rdata_o = mem_q[idx_q];
    end

    assign idx_o  = idx_q;
    assign rate_o = a_q[3:0];
    assign b_o    = b_q;

    // R9: a write with the set bit leaves the update enable low
    assert_set_drops_uie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_n && bus_wr && bus_sel && hit_b && bus_wdata[B_SET]) |=> !b_q[B_UIE]);
    // R11: warm reset clears the periodic, alarm and square-wave enables
    assert_warm_clears_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> ((b_q & B_WARM_CLR) == 8'h00));
endmodule

// File: rtl/crp_flags.sv
// Status register C and the level interrupt. Events set flags; a new
// enabled flag raises the request. A read clears all flags, and events
// in the same cycle as the read win. A write to B re-evaluates the request.
module crp_flags
    import crp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst_n,
    input  logic       rd_c,
    input  logic       wr_b,
    input  logic [7:0] b_wval,
    input  logic [7:0] b_q,
    input  logic [2:0] ev,      // {periodic, alarm, update ended}
    output logic [7:0] c_o,
    output logic       irq_o
);
    logic [7:0] c_q, c_nx, b_eff, ev_pos, fresh;

    // Next value of the status register.
    always_comb begin
        c_nx   = c_q;
        b_eff  = wr_b ? b_wval : b_q;
        ev_pos = {1'b0, ev, 4'b0000};
        if (rd_c)
            c_nx = 8'h00;
        if (wr_b)
            c_nx[C_REQ] = |(b_wval[6:4] & c_nx[6:4]);
        fresh = ev_pos & ~c_nx;
        c_nx  = c_nx | ev_pos;
        if (|(fresh[6:4] & b_eff[6:4]))
            c_nx[C_REQ] = 1'b1;
    end

    // Status register update; warm reset clears it and drops events.
    always_ff @(posedge clk) begin
        if (!rst_n || !warm_rst_n)
            c_q <= 8'h00;
        else
            c_q <= c_nx;
    end

    assign c_o   = c_q;
    assign irq_o = c_q[C_REQ];

    // R5: a request never stands without a latched flag
    assert_req_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_q[C_REQ] |-> (c_q[6:4] != 3'b000));
    // R6: a fresh enabled event raises the interrupt
    assert_event_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_n && !rd_c && !wr_b && ((ev & ~c_q[6:4] & b_q[6:4]) != 3'b000)) |=> irq_o);
    // R7: a read with no event leaves the status register empty
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_n && rd_c && (ev == 3'b000)) |=> (c_q == 8'h00));
    // R8: enabling an already pending flag raises the interrupt
    assert_late_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst_n && wr_b && ((b_wval[6:4] & c_q[6:4]) != 3'b000)) |=> irq_o);
    // R11: warm reset empties the status register
    assert_warm_clears_c_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_rst_n |=> (c_q == 8'h00) && !irq_o);
endmodule

// File: rtl/cmos_regport.sv
// Top of the indexed register port: two-address byte bus, storage,
// control registers, periodic divider and interrupt flags.
// Assumes bus_wr and bus_rd are never high in the same cycle.
module cmos_regport
    import crp_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       warm_rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ref_tick,
    input  logic       upd_done,
    input  logic       alarm_hit,
    input  logic       uip_in,
    output logic       irq
);
    logic [ADDR_W-1:0] idx;
    logic [3:0]        rate;
    logic              rate_chg, wr_b, pf, rd_c;
    logic [7:0]        b_wval, b_cur, store_rd, c_cur;

    crp_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .uip_in(uip_in), .idx_o(idx), .rate_o(rate), .rate_chg_o(rate_chg),
        .wr_b_o(wr_b), .b_wval_o(b_wval), .b_o(b_cur), .rdata_o(store_rd)
    );

    crp_rate_div #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .rate(rate), .restart(rate_chg),
        .tick(ref_tick), .pf_o(pf)
    );

    // Acknowledge strobe for the status register.
    assign rd_c = bus_rd && bus_sel && warm_rst_n && (idx == ADDR_W'(IDX_C));

    crp_flags u_flags (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .rd_c(rd_c),
        .wr_b(wr_b), .b_wval(b_wval), .b_q(b_cur),
        .ev({pf, alarm_hit, upd_done}), .c_o(c_cur), .irq_o(irq)
    );

    // Read data: fixed pattern on the index address, else the indexed byte.
    always_comb begin
        if (!bus_sel)
            bus_rdata = 8'hFF;
        else if (idx == ADDR_W'(IDX_C))
            bus_rdata = c_cur;
        else
            bus_rdata = store_rd;
    end
endmodule

// File: tb/sim_cmos_regport.sv
module sim_cmos_regport;
    logic clk = 0;
    logic rst_n = 0, warm_rst_n = 1;
    logic sel = 0, wr = 0, rd = 0, tick = 0, up = 0, al = 0, uip = 0;
    logic [7:0] wd = 0;
    logic [7:0] rdata;
    logic irq;
    int tests = 0, fails = 0;
    int last_rd;

    // behavioural reference state
    int m_idx, m_a, m_b, m_c, m_cnt;
    int m_mem [128];

    always #10 clk = ~clk;

    cmos_regport u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n), .bus_sel(sel),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wd), .bus_rdata(rdata),
        .ref_tick(tick), .upd_done(up), .alarm_hit(al), .uip_in(uip), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_period(input int n);
        if (n == 0) return 0;
        if (n == 1) return 128;
        if (n == 2) return 256;
        return 1 << (n - 1);
    endfunction

    function automatic int m_read();
        if (!sel) return 'hFF;
        if (m_idx == 12) return m_c;
        if (m_idx == 10) return ((uip && !(m_b & 'h80)) ? 'h80 : 0) | m_a;
        if (m_idx == 11) return m_b;
        if (m_idx == 13) return 'h80;
        return m_mem[m_idx];
    endfunction

    task automatic m_reset();
        m_idx = 0; m_a = 'h26; m_b = 'h02; m_c = 0; m_cnt = 0;
        for (int i = 0; i < 128; i++) m_mem[i] = 0;
    endtask

    // Advance the reference by one clock with the inputs of that cycle.
    task automatic m_update();
        int per, nc, bv, ev, fresh;
        bit chg, pf;
        per = m_period(m_a & 'hF);
        chg = warm_rst_n && wr && sel && m_idx == 10 && ((wd & 'hF) != (m_a & 'hF));
        pf  = tick && per != 0 && m_cnt == per - 1 && !chg;
        if (chg) m_cnt = 0;
        else if (tick && per != 0) m_cnt = (m_cnt == per - 1) ? 0 : m_cnt + 1;
        if (!warm_rst_n) begin
            m_c = 0;
            m_b = m_b & ~'h68;
            m_mem[15] = (m_mem[15] == 'hFE) ? 'hFE : 0;
            return;
        end
        nc = m_c;
        bv = m_b;
        if (rd && sel && m_idx == 12) nc = 0;
        if (wr && sel && m_idx == 11) begin
            bv = (wd & 'h80) ? (wd & ~'h10) : wd;
            if (bv & nc & 'h70) nc = nc | 'h80; else nc = nc & ~'h80;
        end
        ev = (pf ? 'h40 : 0) | (al ? 'h20 : 0) | (up ? 'h10 : 0);
        fresh = ev & ~nc;
        nc = nc | ev;
        if (fresh & bv & 'h70) nc = nc | 'h80;
        m_c = nc;
        m_b = bv;
        if (wr && !sel) m_idx = wd & 'h7F;
        else if (wr && sel) begin
            if (m_idx == 10) m_a = wd & 'h7F;
            else if (m_idx < 10 || m_idx > 13) m_mem[m_idx] = wd;
        end
    endtask

    // One clock: compare against the reference, then advance it.
    task automatic step();
        @(negedge clk);
        #1;
        check("R6 irq vs reference", irq, (m_c >> 7) & 1);
        if (rd) begin
            last_rd = rdata;
            check("R3 read vs reference", rdata, m_read());
        end
        @(posedge clk);
        #1;
        m_update();
        wr = 0; rd = 0; up = 0; al = 0; warm_rst_n = 1;
    endtask

    task automatic set_idx(input int i);
        sel = 0; wr = 1; wd = 8'(i); step();
    endtask

    task automatic put(input int i, input int d);
        set_idx(i); sel = 1; wr = 1; wd = 8'(d); step();
    endtask

    task automatic get(input int i, input int exp, input string tag);
        set_idx(i); sel = 1; rd = 1; step();
        check(tag, last_rd, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R2 irq after reset", irq, 0);
        get(10, 'h26, "R2 reg A reset");
        get(11, 'h02, "R2 reg B reset");
        get(12, 'h00, "R2 reg C reset");
        get(13, 'h80, "R2 reg D reset");
        sel = 0; rd = 1; step();
        check("R1 even read", last_rd, 'hFF);

        // storage and index masking
        put('h20, 'h5A); put('h7F, 'hC3); put('h00, 'h11);
        get('h20, 'h5A, "R3 byte 20");
        get('h7F, 'hC3, "R3 byte 7F");
        get('h00, 'h11, "R3 byte 00");
        put('h8F, 'h77);
        get('h0F, 'h77, "R1 index bit7 dropped");

        // read-only registers
        put(12, 'hFF); get(12, 'h00, "R4 reg C write ignored");
        put(13, 'h00); get(13, 'h80, "R4 reg D write ignored");
        put(10, 'hFF); get(10, 'h7F, "R4 A bit7 not writable");
        uip = 1; get(10, 'hFF, "R4 A bit7 live"); uip = 0;
        put(10, 'h26);

        // flags without enables
        al = 1; step();
        check("R5 alarm no irq", irq, 0);
        get(12, 'h20, "R5 alarm flag bit5");
        get(12, 'h00, "R7 cleared by read");
        up = 1; step();
        get(12, 'h10, "R5 update flag bit4");

        // enabled event, then acknowledge
        put(11, 'h22);
        al = 1; step();
        check("R6 alarm irq", irq, 1);
        get(12, 'hA0, "R6 request bit7");
        check("R7 irq dropped", irq, 0);

        // late enable
        put(11, 'h02);
        up = 1; step();
        check("R8 pending no irq", irq, 0);
        put(11, 'h12);
        check("R8 late enable raises", irq, 1);
        put(11, 'h02);
        check("R8 disable lowers", irq, 0);
        get(12, 'h10, "R8 flag kept");

        // acknowledge racing an event
        set_idx(12); sel = 1; rd = 1; up = 1; step();
        check("R7 read value", last_rd, 'h00);
        get(12, 'h10, "R7 same-cycle event kept");

        // set bit
        put(11, 'h92);
        get(11, 'h82, "R9 set drops bit4");
        uip = 1; get(10, 'h26, "R4 A bit7 masked by set"); uip = 0;
        put(11, 'h02);

        // periodic rates
        put(11, 'h42);
        put(10, 'h23);
        get(12, 'h00, "R10 clear before run");
        tick = 1;
        repeat (3) step();
        check("R10 rate3 not yet", irq, 0);
        step();
        check("R10 rate3 fires at 4", irq, 1);
        tick = 0;
        put(10, 'h21);
        get(12, 'hC0, "R10 periodic flag bit6");
        tick = 1;
        repeat (127) step();
        check("R10 rate1 not yet", irq, 0);
        step();
        check("R10 rate1 fires at 128", irq, 1);
        tick = 0;
        put(10, 'h20);
        get(12, 'hC0, "R10 rate1 flag");
        tick = 1;
        repeat (300) step();
        tick = 0;
        check("R10 rate0 silent", irq, 0);
        get(12, 'h00, "R10 rate0 no flag");

        // warm reset with marker
        put('h0F, 'hFE); put('h30, 'h44); put(11, 'h6A);
        al = 1; step();
        check("R11 irq before warm", irq, 1);
        warm_rst_n = 0; step();
        check("R11 irq after warm", irq, 0);
        get(11, 'h02, "R11 enables cleared");
        get(12, 'h00, "R11 flags cleared");
        get('h0F, 'hFE, "R11 marker kept");
        get('h30, 'h44, "R11 storage kept");
        get(10, 'h20, "R11 reg A kept");
        put('h0F, 'h12);
        warm_rst_n = 0; step();
        get('h0F, 'h00, "R11 non-marker zeroed");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule